// File: doc/BRIEF.md
# Tiled Integer Matrix Multiply Engine

The engine computes the product C = A x B of two signed 16-bit integer matrices whose shapes (M rows of A, K shared inner length, N columns of B) are fixed by parameters. Operands sit in two external word-addressed memories that the engine reads through plain synchronous read ports. Results leave through a plain write port, one 40-bit element per write.

Work is split into square output tiles of edge T. For each output tile the engine walks the inner dimension in ceil(K / T) steps. Each step copies a T x T piece of A and of B into one of two local buffer sets, and an array of T x T multiply-accumulators then works only from that buffer set. While the array consumes one set, the loader fills the other with the next inner-dimension piece, and the two sets swap after every step. Positions that fall outside a matrix are filled with zero, so ragged edges need no separate arithmetic. Once the final inner step is done, the tile's accumulators are written out and cleared for the next tile.

A one-cycle `start` pulse launches a whole multiply. `busy` stays high until the run finishes, and `done` pulses for one cycle right after the final result write.

Top module: `tiled_matmul`

## Requirements
- R1: Each written result equals the sum over k of A[row][k] * B[k][col], computed as a signed product with a 40-bit two's-complement accumulator.
- R2: Element A[row][k] is read at address row*K + k and element B[k][col] at address k*N + col. Read data is taken in the clock cycle after the read enable.
- R3: No read is issued for a tile position outside a matrix. Such positions count as zero. Over one run, A is read exactly M*K*ceil(N/T) times and B is read exactly K*N*ceil(M/T) times.
- R4: Each in-range C element is written exactly once, at address row*N + col, after all ceil(K/T) inner steps of its tile. Writes follow this order: row band, then column band, then row inside the tile, then column inside the tile.
- R5: No write is issued for a row at or above M or a column at or above N.
- R6: The loader never writes into the buffer set the accumulator array is reading in that cycle, and a new tile load starts only when the previous load has finished.
- R7: A `start` pulse that arrives while `busy` is high has no effect on the reads, writes or `done` of the run in progress.
- R8: `busy` rises in the cycle after an accepted `start` and stays high until the run ends. `done` is high for exactly one cycle, and that cycle directly follows the last result write.
- R9: After reset, `busy`, `done` and all read and write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a multiply (ignored while busy) |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse after the last result write |
| a_rd_en | output | 1 | Read enable for the A memory |
| a_rd_addr | output | $clog2(M*K) | Word address into A |
| a_rd_data | input | 16 | A word, valid the cycle after a_rd_en |
| b_rd_en | output | 1 | Read enable for the B memory |
| b_rd_addr | output | $clog2(K*N) | Word address into B |
| b_rd_data | input | 16 | B word, valid the cycle after b_rd_en |
| c_wr_en | output | 1 | Result write strobe |
| c_wr_addr | output | $clog2(M*N) | Word address into C |
| c_wr_data | output | 40 | Signed result |

## Verification
The assertions assume that the operand memories answer every enabled read exactly one cycle later, and that operand contents do not change during a run. The bench memory model meets both: it registers the addressed word on each enabled read, drives a fixed junk value on cycles with no read, and changes the arrays only between runs. The assertions place no constraint on `start`. The bench therefore pulses it both while the engine is idle and in the middle of a run, so the rule that a `start` during `busy` is ignored is exercised rather than assumed.

// File: rtl/tmm_pkg.sv
package tmm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRO,
    ST_STEP,
    ST_WRITE,
    ST_FLUSH
  } tmm_state_e;

  // ceiling of n / d
  function automatic int unsigned cdiv(input int unsigned n, input int unsigned d);
    return (n + d - 1) / d;
  endfunction

  // how many valid rows (or columns) band b holds for a matrix extent
  function automatic int unsigned band_span(input int unsigned extent,
                                            input int unsigned t,
                                            input int unsigned b);
    int unsigned rem;
    rem = extent - b * t;
    return (rem >= t) ? t : rem;
  endfunction

  // index of the last in-range element of a tile, row-major inside the tile
  function automatic int unsigned tile_last(input int unsigned rows_ok,
                                            input int unsigned cols_ok,
                                            input int unsigned t);
    return (rows_ok - 1) * t + cols_ok - 1;
  endfunction

endpackage

// File: rtl/tmm_loader.sv
module tmm_loader #(
  parameter int T   = 4,
  parameter int DW  = 16,
  parameter int M   = 5,
  parameter int N   = 6,
  parameter int K   = 7,
  parameter int AAW = 6,
  parameter int BAW = 6,
  localparam int TT  = T * T,
  localparam int IXW = $clog2(TT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic                  sel,
  input  int unsigned           row0,
  input  int unsigned           col0,
  input  int unsigned           k0,
  output logic                  a_rd_en,
  output logic [AAW-1:0]        a_rd_addr,
  input  logic signed [DW-1:0]  a_rd_data,
  output logic                  b_rd_en,
  output logic [BAW-1:0]        b_rd_addr,
  input  logic signed [DW-1:0]  b_rd_data,
  output logic                  wr_en,
  output logic                  wr_sel,
  output logic [IXW-1:0]        wr_idx,
  output logic signed [DW-1:0]  wr_a,
  output logic signed [DW-1:0]  wr_b,
  output logic                  busy
);

  logic           active;
  logic [IXW-1:0] idx;
  logic           tsel;
  int unsigned    r0, c0, kb;

  logic           pv, pa_in, pb_in, psel;
  logic [IXW-1:0] pidx;

  int unsigned lr, lc, ga_row, ga_k, gb_k, gb_col;
  logic        a_in, b_in;

  always_comb begin
    lr     = 32'(idx) / T;
    lc     = 32'(idx) % T;
    ga_row = r0 + lr;
    ga_k   = kb + lc;
    gb_k   = kb + lr;
    gb_col = c0 + lc;
    a_in   = active && (ga_row < M) && (ga_k < K);
    b_in   = active && (gb_k < K) && (gb_col < N);
  end

  assign a_rd_en   = a_in;
  assign a_rd_addr = AAW'(ga_row * K + ga_k);
  assign b_rd_en   = b_in;
  assign b_rd_addr = BAW'(gb_k * N + gb_col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      tsel   <= 1'b0;
      r0     <= 0;
      c0     <= 0;
      kb     <= 0;
      pv     <= 1'b0;
      pidx   <= '0;
      pa_in  <= 1'b0;
      pb_in  <= 1'b0;
      psel   <= 1'b0;
    end else begin
      pv    <= active;
      pidx  <= idx;
      pa_in <= a_in;
      pb_in <= b_in;
      psel  <= tsel;
      if (go && !busy) begin
        active <= 1'b1;
        idx    <= '0;
        tsel   <= sel;
        r0     <= row0;
        c0     <= col0;
        kb     <= k0;
      end else if (active) begin
        if (idx == IXW'(TT - 1)) active <= 1'b0;
        idx <= idx + 1'b1;
      end
    end
  end

  // zero-fill: out-of-range positions never take the port data
  assign wr_en  = pv;
  assign wr_sel = psel;
  assign wr_idx = pidx;
  assign wr_a   = pa_in ? a_rd_data : '0;
  assign wr_b   = pb_in ? b_rd_data : '0;
  assign busy   = active | pv;

  // R3: reads stay inside the operand arrays
  p_rd_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd_en |-> a_rd_addr < AAW'(M * K)) and (b_rd_en |-> b_rd_addr < BAW'(K * N)));

  // R6: a new load is only launched once the previous one has drained
  p_go_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);

endmodule

// File: rtl/tmm_tilebuf.sv
module tmm_tilebuf #(
  parameter int T  = 4,
  parameter int DW = 16,
  localparam int TT  = T * T,
  localparam int IXW = $clog2(TT)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [IXW-1:0]       wr_idx,
  input  logic signed [DW-1:0] wr_a,
  input  logic signed [DW-1:0] wr_b,
  input  logic                 rd_sel,
  output logic signed [DW-1:0] a_tile [TT],
  output logic signed [DW-1:0] b_tile [TT]
);

  logic signed [DW-1:0] amem [2][TT];
  logic signed [DW-1:0] bmem [2][TT];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      amem[wr_sel][wr_idx] <= wr_a;
      bmem[wr_sel][wr_idx] <= wr_b;
    end
  end

  always_comb begin
    for (int e = 0; e < TT; e++) begin
      a_tile[e] = amem[rd_sel][e];
      b_tile[e] = bmem[rd_sel][e];
    end
  end

endmodule

// File: rtl/tmm_macarray.sv
module tmm_macarray #(
  parameter int T  = 4,
  parameter int DW = 16,
  parameter int AW = 40,
  localparam int TT  = T * T,
  localparam int KKW = $clog2(T)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic [KKW-1:0]       kk,
  input  logic signed [DW-1:0] a_tile [TT],
  input  logic signed [DW-1:0] b_tile [TT],
  output logic signed [AW-1:0] acc [TT]
);

  // one multiply-accumulate, wrapping at AW bits
  function automatic logic signed [AW-1:0] mac_step(input logic signed [AW-1:0] sum,
                                                    input logic signed [DW-1:0] x,
                                                    input logic signed [DW-1:0] y);
    logic signed [2*DW-1:0] p;
    p = x * y;
    return sum + {{(AW - 2*DW){p[2*DW-1]}}, p};
  endfunction

  for (genvar gi = 0; gi < T; gi++) begin : g_row
    for (genvar gj = 0; gj < T; gj++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc[gi*T+gj] <= '0;
        else if (clr) acc[gi*T+gj] <= '0;
        else if (en)  acc[gi*T+gj] <= mac_step(acc[gi*T+gj],
                                               a_tile[gi*T + 32'(kk)],
                                               b_tile[32'(kk)*T + gj]);
      end
    end
  end

  // R4: a tile's sums are never cleared in a cycle that is still adding to them
  p_clr_not_during_mac_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !clr);

endmodule

// File: rtl/tiled_matmul.sv
module tiled_matmul
  import tmm_pkg::*;
#(
  parameter int M  = 5,
  parameter int N  = 6,
  parameter int K  = 7,
  parameter int T  = 4,
  parameter int DW = 16,
  parameter int AW = 40,
  localparam int AAW = $clog2(M * K),
  localparam int BAW = $clog2(K * N),
  localparam int CAW = $clog2(M * N),
  localparam int TT  = T * T,
  localparam int IXW = $clog2(TT),
  localparam int KKW = $clog2(T),
  localparam int RB  = cdiv(M, T),
  localparam int CB  = cdiv(N, T),
  localparam int KT  = cdiv(K, T)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic                 a_rd_en,
  output logic [AAW-1:0]       a_rd_addr,
  input  logic signed [DW-1:0] a_rd_data,
  output logic                 b_rd_en,
  output logic [BAW-1:0]       b_rd_addr,
  input  logic signed [DW-1:0] b_rd_data,
  output logic                 c_wr_en,
  output logic [CAW-1:0]       c_wr_addr,
  output logic signed [AW-1:0] c_wr_data
);

  tmm_state_e     st;
  int unsigned    bi, bj, kt;
  logic           cur;
  logic [KKW-1:0] kk;
  logic           cmp_run;
  logic [IXW-1:0] widx;

  // named internal events
  logic ev_pro_end, ev_step_end, ev_last_k, ev_wr_last, ev_tile_last;
  logic mac_en, mac_clr;

  logic        ld_go, ld_sel, ld_busy;
  int unsigned ld_row0, ld_col0, ld_k0;
  int unsigned nbi, nbj;

  logic                 ld_wr_en, ld_wr_sel;
  logic [IXW-1:0]       ld_wr_idx;
  logic signed [DW-1:0] ld_wr_a, ld_wr_b;
  logic signed [DW-1:0] a_tile [TT];
  logic signed [DW-1:0] b_tile [TT];
  logic signed [AW-1:0] acc [TT];

  int unsigned w_row, w_col;
  logic        w_in;

  always_comb begin
    ev_pro_end   = (st == ST_PRO) && !ld_busy;
    ev_step_end  = (st == ST_STEP) && !cmp_run && !ld_busy;
    ev_last_k    = (kt == KT - 1);
    ev_tile_last = (bi == RB - 1) && (bj == CB - 1);
    w_row        = bi * T + 32'(widx) / T;
    w_col        = bj * T + 32'(widx) % T;
    w_in         = (st == ST_WRITE) && (w_row < M) && (w_col < N);
    ev_wr_last   = (st == ST_WRITE) &&
                   (32'(widx) == tile_last(band_span(M, T, bi), band_span(N, T, bj), T));
    mac_en       = (st == ST_STEP) && cmp_run;
    mac_clr      = ((st == ST_IDLE) && start) || (ev_wr_last && !ev_tile_last);

    nbi = bi;
    nbj = bj + 1;
    if (bj == CB - 1) begin
      nbj = 0;
      nbi = bi + 1;
    end

    ld_go   = 1'b0;
    ld_sel  = cur;
    ld_row0 = bi * T;
    ld_col0 = bj * T;
    ld_k0   = 0;
    if ((st == ST_IDLE) && start) begin
      ld_go   = 1'b1;
      ld_row0 = 0;
      ld_col0 = 0;
    end else if (ev_pro_end && (KT > 1)) begin
      ld_go  = 1'b1;
      ld_sel = ~cur;
      ld_k0  = T;
    end else if (ev_step_end && (kt + 2 < KT)) begin
      ld_go  = 1'b1;
      ld_sel = cur;
      ld_k0  = (kt + 2) * T;
    end else if (ev_wr_last && !ev_tile_last) begin
      ld_go   = 1'b1;
      ld_row0 = nbi * T;
      ld_col0 = nbj * T;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bi        <= 0;
      bj        <= 0;
      kt        <= 0;
      cur       <= 1'b0;
      kk        <= '0;
      cmp_run   <= 1'b0;
      widx      <= '0;
      done      <= 1'b0;
      c_wr_en   <= 1'b0;
      c_wr_addr <= '0;
      c_wr_data <= '0;
    end else begin
      done    <= 1'b0;
      c_wr_en <= w_in;
      if (mac_en) begin
        kk <= kk + 1'b1;
        if (kk == KKW'(T - 1)) cmp_run <= 1'b0;
      end
      unique case (st)
        ST_IDLE: if (start) begin
          st <= ST_PRO;
          bi <= 0;
          bj <= 0;
        end
        ST_PRO: if (ev_pro_end) begin
          st      <= ST_STEP;
          kt      <= 0;
          kk      <= '0;
          cmp_run <= 1'b1;
        end
        ST_STEP: if (ev_step_end) begin
          if (ev_last_k) begin
            st   <= ST_WRITE;
            widx <= '0;
          end else begin
            kt      <= kt + 1;
            cur     <= ~cur;
            kk      <= '0;
            cmp_run <= 1'b1;
          end
        end
        ST_WRITE: begin
          c_wr_addr <= CAW'(w_row * N + w_col);
          c_wr_data <= acc[widx];
          widx      <= widx + 1'b1;
          if (ev_wr_last) begin
            if (ev_tile_last) st <= ST_FLUSH;
            else begin
              st <= ST_PRO;
              bi <= nbi;
              bj <= nbj;
            end
          end
        end
        ST_FLUSH: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);

  tmm_loader #(.T(T), .DW(DW), .M(M), .N(N), .K(K), .AAW(AAW), .BAW(BAW)) u_loader (
    .clk(clk), .rst_n(rst_n), .go(ld_go), .sel(ld_sel),
    .row0(ld_row0), .col0(ld_col0), .k0(ld_k0),
    .a_rd_en(a_rd_en), .a_rd_addr(a_rd_addr), .a_rd_data(a_rd_data),
    .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
    .wr_en(ld_wr_en), .wr_sel(ld_wr_sel), .wr_idx(ld_wr_idx),
    .wr_a(ld_wr_a), .wr_b(ld_wr_b), .busy(ld_busy)
  );

  tmm_tilebuf #(.T(T), .DW(DW)) u_buf (
    .clk(clk), .wr_en(ld_wr_en), .wr_sel(ld_wr_sel), .wr_idx(ld_wr_idx),
    .wr_a(ld_wr_a), .wr_b(ld_wr_b), .rd_sel(cur),
    .a_tile(a_tile), .b_tile(b_tile)
  );

  tmm_macarray #(.T(T), .DW(DW), .AW(AW)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(mac_clr), .en(mac_en), .kk(kk),
    .a_tile(a_tile), .b_tile(b_tile), .acc(acc)
  );

  // R6: the loader and the accumulator array never share a buffer set in one cycle
  p_ld_other_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && ld_wr_en) |-> (ld_wr_sel != cur));

  // R5: result addresses stay inside C
  p_wr_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_en |-> (c_wr_addr < CAW'(M * N)));

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done directly follows a result write
  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(c_wr_en));

  // R4: no result leaves while the accumulator array is still adding
  p_no_write_mid_mac_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en |-> !c_wr_en);

endmodule

// File: tb/tb_tiled_matmul.sv
module tb_tiled_matmul;

  localparam int M  = 5;
  localparam int N  = 6;
  localparam int K  = 7;
  localparam int T  = 4;
  localparam int DW = 16;
  localparam int AW = 40;
  localparam int AAW = $clog2(M * K);
  localparam int BAW = $clog2(K * N);
  localparam int CAW = $clog2(M * N);
  localparam int RB = (M + T - 1) / T;
  localparam int CB = (N + T - 1) / T;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done;
  logic a_rd_en, b_rd_en, c_wr_en;
  logic [AAW-1:0] a_rd_addr;
  logic [BAW-1:0] b_rd_addr;
  logic [CAW-1:0] c_wr_addr;
  logic signed [DW-1:0] a_rd_data, b_rd_data;
  logic signed [AW-1:0] c_wr_data;

  always #4 clk = ~clk;

  tiled_matmul #(.M(M), .N(N), .K(K), .T(T), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .a_rd_en(a_rd_en), .a_rd_addr(a_rd_addr), .a_rd_data(a_rd_data),
    .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
    .c_wr_en(c_wr_en), .c_wr_addr(c_wr_addr), .c_wr_data(c_wr_data)
  );

  logic signed [DW-1:0] amem [M*K];
  logic signed [DW-1:0] bmem [K*N];

  // one-cycle read latency; junk when no read is issued
  always @(posedge clk) begin
    a_rd_data <= a_rd_en ? amem[a_rd_addr] : 16'sh7777;
    b_rd_data <= b_rd_en ? bmem[b_rd_addr] : -16'sh1357;
  end

  int total = 0;
  int bad = 0;
  int exp_addr [$];
  logic [AW-1:0] exp_data [$];
  int a_reads, b_reads, done_cnt, cyc, last_wr_cyc;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      cyc++;
      if (c_wr_en) begin
        if (exp_addr.size() == 0) chk(1'b0, "R4 extra write", c_wr_addr, -1);
        else begin
          int ea;
          logic [AW-1:0] ed;
          ea = exp_addr.pop_front();
          ed = exp_data.pop_front();
          chk(c_wr_addr == CAW'(ea), "R4 write address", c_wr_addr, ea);
          chk(c_wr_data == ed, "R1 result value", c_wr_data, ed);
        end
        last_wr_cyc = cyc;
      end
      if (a_rd_en) begin
        a_reads++;
        if (a_rd_addr >= AAW'(M * K)) chk(1'b0, "R3 A address range", a_rd_addr, M * K);
      end
      if (b_rd_en) begin
        b_reads++;
        if (b_rd_addr >= BAW'(K * N)) chk(1'b0, "R3 B address range", b_rd_addr, K * N);
      end
      if (done) begin
        done_cnt++;
        chk(last_wr_cyc == cyc - 1, "R8 done follows last write", last_wr_cyc, cyc - 1);
        chk(!busy, "R8 busy low at done", busy, 0);
      end
    end
  end

  // reference: row band, column band, then row-major inside the tile
  task automatic build_expect();
    exp_addr.delete();
    exp_data.delete();
    for (int bi = 0; bi < RB; bi++)
      for (int bj = 0; bj < CB; bj++)
        for (int r = 0; r < T; r++)
          for (int c = 0; c < T; c++) begin
            int row, col;
            longint s;
            row = bi * T + r;
            col = bj * T + c;
            if (row < M && col < N) begin
              s = 0;
              for (int k = 0; k < K; k++)
                s += longint'(amem[row*K+k]) * longint'(bmem[k*N+col]);
              exp_addr.push_back(row * N + col);
              exp_data.push_back(s[AW-1:0]);
            end
          end
  endtask

  task automatic run(input string name, input bit poke);
    bit fin;
    build_expect();
    a_reads = 0;
    b_reads = 0;
    done_cnt = 0;
    mon_on = 1'b1;
    @(negedge clk);
    #1 start = 1'b1;
    @(negedge clk);
    #1 start = 1'b0;
    chk(busy, "R8 busy after start", busy, 1);
    fin = 1'b0;
    for (int w = 0; w < 5000 && !fin; w++) begin
      @(negedge clk);
      #1;
      if (poke && (w == 25 || w == 90)) begin
        chk(busy, "R7 poke lands while busy", busy, 1);
        start = 1'b1;
      end else start = 1'b0;
      if (done_cnt > 0) fin = 1'b1;
      else chk(busy, "R8 busy until done", busy, 1);
    end
    start = 1'b0;
    if (!fin) chk(1'b0, "watchdog", 0, 1);
    repeat (4) @(negedge clk);
    #1;
    chk(done_cnt == 1, "R7 single done per run", done_cnt, 1);
    chk(!busy, "R7 idle after run", busy, 0);
    chk(exp_addr.size() == 0, "R4 all results written", exp_addr.size(), 0);
    chk(a_reads == M * K * CB, "R3 A read count", a_reads, M * K * CB);
    chk(b_reads == K * N * RB, "R3 B read count", b_reads, K * N * RB);
    mon_on = 1'b0;
    $display("run %s finished", name);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !done, "R9 busy/done in reset", {busy, done}, 0);
    chk(!a_rd_en && !b_rd_en && !c_wr_en, "R9 enables in reset", {a_rd_en, b_rd_en, c_wr_en}, 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !c_wr_en, "R9 idle after reset", {busy, done, c_wr_en}, 0);

    // R1 R2: random operands
    for (int i = 0; i < M * K; i++) amem[i] = DW'($urandom);
    for (int i = 0; i < K * N; i++) bmem[i] = DW'($urandom);
    run("random", 1'b0);

    // R1: most negative operands, sums need more than 32 bits
    for (int i = 0; i < M * K; i++) amem[i] = -16'sd32768;
    for (int i = 0; i < K * N; i++) bmem[i] = -16'sd32768;
    run("extreme", 1'b0);

    // R2 R5: distinct addressing pattern, mixed signs
    for (int i = 0; i < M * K; i++) amem[i] = DW'(((i % K) == (i / K)) ? 1 : -(i % 5));
    for (int i = 0; i < K * N; i++) bmem[i] = DW'(i * 37 - 500);
    run("pattern", 1'b0);

    // R7: start pulses in the middle of a run
    for (int i = 0; i < M * K; i++) amem[i] = DW'($urandom_range(0, 2000)) - 16'sd1000;
    for (int i = 0; i < K * N; i++) bmem[i] = DW'($urandom);
    run("poke", 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule